// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block drives the two-wire management bus of an Ethernet PHY (clause 22 frames only). Software programs a PHY number and a register number into an address register and, for writes, a 16-bit value into a write-data register. Setting a request bit in the control register then starts one management frame. The frame is shifted out on the management clock and data pins. A status bit reads 1 until the frame has finished. For a read, the 16 bits that the PHY returns are captured into a read-data register.

The management clock is made from the system clock by a divider. The `DIV_HALF` parameter sets the number of system cycles in each MDC half period. The default of 21 gives about 2.38 MHz from a 100 MHz clock. A register bank decodes the register port. A clock generator makes the MDC phase pulses. A state machine walks the frame through five states:
- `ST_IDLE`: no frame in progress.
- `ST_PRE`: 32 preamble ones.
- `ST_HDR`: 14 bits made up of the start code, the opcode, the PHY number and the register number.
- `ST_TA`: two turnaround bits.
- `ST_DATA`: 16 data bits.

The state machine moves through these states as follows:
- IDLE→PRE when a request is accepted.
- PRE→HDR after the 32nd preamble bit.
- HDR→TA after the 14th header bit.
- TA→DATA after the second turnaround bit.
- DATA→IDLE after the 16th data bit.

Each move happens on an MDC falling phase.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The register offsets are fixed:
  - control at 0x214
  - address at 0x218
  - write data at 0x21C
  - status at 0x220
  - read data at 0x224

  The address register keeps the PHY number in bits 12:8 and the register number in bits 4:0. The write-data register keeps bits 15:0. All other bits of these registers read back as zero.
- R2: A control write with bit 3 set requests a read. A control write with bit 2 set and bit 3 clear requests a write. If both bits are set, the request is a read. A control write with neither bit set starts nothing.
- R3: Status bit 0 reads 1 from the cycle after a request is accepted, for exactly 128×DIV_HALF cycles, and then returns to 0.
- R4: MDC is low whenever the block is idle. During a frame, MDC starts low and toggles every DIV_HALF system cycles. A frame therefore has 64 MDC periods and ends on a falling edge.
- R5: A frame is sent MSB first and consists of:
  - 32 ones
  - the start code 01
  - the opcode: 10 for a read, 01 for a write
  - the 5-bit PHY number
  - the 5-bit register number
  - the turnaround 10 (on a write)
  - 16 data bits

  MDIO output and output enable change only on MDC falling edges.
- R6: On a read, the output enable is low from the first turnaround bit to the end of the frame. The input is sampled on each MDC rising edge of the data bits. The 16 sampled bits, first sample in bit 15, are placed into the read-data register when the frame ends.
- R7: Read-data bits 31:16 read as zero. The read-data value changes only when a read frame completes.
- R8: While a frame runs, control reads back its request: bit 3 for a read, bit 2 for a write. When the frame completes, the request bit clears itself.
- R9: A control write that arrives while status is busy has no effect on the frame in progress or on the control readback.
- R10: After reset, all registers read 0, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for both reads and writes |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value, decoded combinationally from reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong state or bit count shows up at the pins within one MDC half period. In that half period, MDC, the output enable or the driven bit disagrees with the frame that the cycle-by-cycle reference predicts from the register writes. A lost completion leaves the status bit high past 128×DIV_HALF cycles, and the per-clock status comparison catches this on the first cycle late. A read path fault, such as wrong sampling phase, bit order or a latch at the wrong time, appears as a read-data value that differs from the behavioural PHY's register contents. This is checked right after each read completes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int REG_ADDR_W = 12;
    localparam int REG_DATA_W = 32;

    localparam logic [REG_ADDR_W-1:0] OFS_CTRL  = 12'h214;
    localparam logic [REG_ADDR_W-1:0] OFS_ADDR  = 12'h218;
    localparam logic [REG_ADDR_W-1:0] OFS_WDATA = 12'h21C;
    localparam logic [REG_ADDR_W-1:0] OFS_STAT  = 12'h220;
    localparam logic [REG_ADDR_W-1:0] OFS_RDATA = 12'h224;

    localparam int CTRL_RD_BIT = 3;
    localparam int CTRL_WR_BIT = 2;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_HALF = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rise_tick = run && (cnt == LAST) && !mdc;
    assign fall_tick = run && (cnt == LAST) && mdc;
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        start_read,
    input  logic [4:0]  phy_num,
    input  logic [4:0]  reg_num,
    input  logic [15:0] wr_data,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    mdio_state_t state;
    logic [4:0]  bit_cnt;
    logic [31:0] shreg;
    logic [15:0] rd_sh;
    logic        is_read;

    assign done = (state == ST_DATA) && fall_tick && (bit_cnt == 5'(DATA_BITS - 1));

    // state register, bit counter and shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            rd_sh   <= '0;
            rd_data <= '0;
            is_read <= 1'b0;
        end else begin
            if (rise_tick && (state == ST_DATA) && is_read)
                rd_sh <= {rd_sh[14:0], mdio_i};
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_PRE;
                        bit_cnt <= '0;
                        is_read <= start_read;
                        shreg   <= {2'b01, (start_read ? 2'b10 : 2'b01), phy_num, reg_num,
                                    (start_read ? 2'b00 : 2'b10),
                                    (start_read ? 16'h0000 : wr_data)};
                    end
                end
                ST_PRE: begin
                    if (fall_tick) begin
                        if (bit_cnt == 5'(PRE_BITS - 1)) begin
                            state   <= ST_HDR;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_HDR: begin
                    if (fall_tick) begin
                        shreg <= {shreg[30:0], 1'b0};
                        if (bit_cnt == 5'(HDR_BITS - 1)) begin
                            state   <= ST_TA;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_TA: begin
                    if (fall_tick) begin
                        shreg <= {shreg[30:0], 1'b0};
                        if (bit_cnt == 5'(TA_BITS - 1)) begin
                            state   <= ST_DATA;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (fall_tick) begin
                        shreg <= {shreg[30:0], 1'b0};
                        if (bit_cnt == 5'(DATA_BITS - 1)) begin
                            state   <= ST_IDLE;
                            bit_cnt <= '0;
                            if (is_read)
                                rd_data <= rd_sh;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_PRE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_HDR: begin
                mdio_oe = 1'b1;
                mdio_o  = shreg[31];
            end
            ST_TA, ST_DATA: begin
                mdio_oe = !is_read;
                mdio_o  = !is_read && shreg[31];
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wen,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output logic                  mdc,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    input  logic                  mdio_i
);
    logic [4:0]  phy_q, regn_q;
    logic [15:0] wd_q;
    logic        req_rd, req_wr;
    logic        busy, done, start, start_read;
    logic        rise_tick, fall_tick;
    logic [15:0] rd_data;
    logic        unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_DATA_W-1:16];

    assign start = reg_wen && (reg_addr == OFS_CTRL) && !busy &&
                   (reg_wdata[CTRL_RD_BIT] || reg_wdata[CTRL_WR_BIT]);
    assign start_read = reg_wdata[CTRL_RD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_q  <= '0;
            regn_q <= '0;
            wd_q   <= '0;
            req_rd <= 1'b0;
            req_wr <= 1'b0;
        end else begin
            if (reg_wen && (reg_addr == OFS_ADDR)) begin
                phy_q  <= reg_wdata[12:8];
                regn_q <= reg_wdata[4:0];
            end
            if (reg_wen && (reg_addr == OFS_WDATA))
                wd_q <= reg_wdata[15:0];
            if (start) begin
                req_rd <= start_read;
                req_wr <= !start_read;
            end else if (done) begin
                req_rd <= 1'b0;
                req_wr <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata[CTRL_RD_BIT:CTRL_WR_BIT] = {req_rd, req_wr};
            OFS_ADDR:  reg_rdata[12:0] = {phy_q, 3'b000, regn_q};
            OFS_WDATA: reg_rdata[15:0] = wd_q;
            OFS_STAT:  reg_rdata[0] = busy;
            OFS_RDATA: reg_rdata[15:0] = rd_data;
            default:   reg_rdata = '0;
        endcase
    end

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) clkgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_read (start_read),
        .phy_num    (phy_q),
        .reg_num    (regn_q),
        .wr_data    (wd_q),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .done       (done),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
    parameter int DIV_HALF = 21
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic [15:0] rd_data
);
    logic mdc_q, seen;
    int   hc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_q <= 1'b0;
            seen  <= 1'b0;
            hc    <= 0;
        end else begin
            mdc_q <= mdc;
            if (mdc != mdc_q) begin
                hc   <= 0;
                seen <= 1'b1;
            end else begin
                hc <= busy ? hc + 1 : 0;
                if (!busy) seen <= 1'b0;
            end
        end
    end

    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R4

    AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mdc != mdc_q) && seen) |-> (hc == DIV_HALF - 1)); // R4

    AST_DATA_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R5

    AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(mdc)); // R3

    AST_RDATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(rd_data)); // R7
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.DIV_HALF(DIV_HALF)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .rd_data (rd_data)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
    import mdio_pkg::*;

    localparam int DIV = 21;
    localparam int FRAME_CYC = 128 * DIV;
    localparam logic [4:0] PHY_ADDR = 5'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wen;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_line;

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural PHY
    logic [15:0] phy_mem [32];
    int          ph_phase = 0, ph_ones = 0, ph_cnt = 0;
    logic [11:0] ph_hdr;
    logic [15:0] ph_word;
    logic        ph_drv = 1'b0, ph_bit = 1'b1, ph_rdm = 1'b0;

    assign mdio_line = mdio_oe ? mdio_o : (ph_drv ? ph_bit : 1'b1);

    mdio_mgmt_ctrl #(.DIV_HALF(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    function automatic logic [15:0] init_word(int i);
        return 16'hC000 ^ (16'(i) * 16'h0111);
    endfunction

    initial for (int i = 0; i < 32; i++) phy_mem[i] = init_word(i);

    always @(posedge mdc) begin
        case (ph_phase)
            0: begin
                if (mdio_line) ph_ones++;
                else if (ph_ones >= 32) ph_phase = 1;
                else ph_ones = 0;
            end
            1: begin
                ph_phase = mdio_line ? 2 : 0;
                ph_ones = 0; ph_cnt = 0;
            end
            2: begin
                ph_hdr = {ph_hdr[10:0], mdio_line};
                ph_cnt++;
                if (ph_cnt == 12) begin
                    ph_phase = 3; ph_cnt = 0;
                    ph_rdm = (ph_hdr[11:10] == 2'b10) && (ph_hdr[9:5] == PHY_ADDR);
                    ph_word = phy_mem[ph_hdr[4:0]];
                end
            end
            3: begin
                ph_cnt++;
                if (ph_cnt == 2) begin ph_phase = 4; ph_cnt = 0; end
            end
            default: begin
                ph_word = ph_rdm ? ph_word : {ph_word[14:0], mdio_line};
                ph_cnt++;
                if (ph_cnt == 16) begin
                    if (ph_hdr[11:10] == 2'b01 && ph_hdr[9:5] == PHY_ADDR)
                        phy_mem[ph_hdr[4:0]] = ph_word;
                    ph_phase = 0; ph_drv = 1'b0; ph_rdm = 1'b0;
                end
            end
        endcase
    end

    always @(negedge mdc) begin
        if (ph_phase == 4 && ph_rdm) begin
            ph_drv = 1'b1;
            ph_bit = ph_word[15 - ph_cnt];
        end
    end

    // reference model, advanced at each clock edge
    bit          m_txn, m_rd;
    int          m_n;
    logic [4:0]  a_phy, a_reg, m_phy, m_reg;
    logic [15:0] a_wd, m_wd, m_rdata;
    logic [63:0] m_frame;
    logic [15:0] ref_mem [32];

    initial for (int i = 0; i < 32; i++) ref_mem[i] = init_word(i);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txn = 0; m_n = 0; a_phy = 0; a_reg = 0; a_wd = 0; m_rdata = 0;
        end else begin
            if (m_txn) begin
                m_n++;
                if (m_n == FRAME_CYC) begin
                    m_txn = 0;
                    if (m_rd) m_rdata = (m_phy == PHY_ADDR) ? ref_mem[m_reg] : 16'hFFFF;
                    else if (m_phy == PHY_ADDR) ref_mem[m_reg] = m_wd;
                end
            end else if (reg_wen && reg_addr == OFS_CTRL && (reg_wdata[3] || reg_wdata[2])) begin
                m_txn = 1; m_n = 0; m_rd = reg_wdata[3];
                m_phy = a_phy; m_reg = a_reg; m_wd = a_wd;
                m_frame = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), m_phy, m_reg, 2'b10, m_wd};
            end
            if (reg_wen && reg_addr == OFS_ADDR) begin a_phy = reg_wdata[12:8]; a_reg = reg_wdata[4:0]; end
            if (reg_wen && reg_addr == OFS_WDATA) a_wd = reg_wdata[15:0];
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from the edge
    always begin
        @(posedge clk);
        #2;
        if (rst_n) begin
            int  idx;
            bit  e_mdc, e_oe;
            idx   = m_n / (2 * DIV);
            e_mdc = m_txn && (((m_n / DIV) % 2) == 1);
            e_oe  = m_txn && (!m_rd || idx < 46);
            chk("R4 mdc", {31'b0, mdc}, {31'b0, e_mdc});
            chk("R5/R6 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) chk("R5 mdio_o", {31'b0, mdio_o}, {31'b0, m_frame[63 - idx]});
            if (reg_addr == OFS_STAT) chk("R3 status", reg_rdata, {31'b0, m_txn});
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0; reg_addr = OFS_STAT; reg_wdata = '0;
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
        reg_addr = OFS_STAT;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_txn) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0; reg_wen = 1'b0; reg_addr = OFS_STAT; reg_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R10 mdc", {31'b0, mdc}, 32'd0);
        chk("R10 oe", {31'b0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        rd_chk("R10 ctrl", OFS_CTRL, 32'h0);
        rd_chk("R10 status", OFS_STAT, 32'h0);
        rd_chk("R10 rdata", OFS_RDATA, 32'h0);
        rd_chk("R10 addr", OFS_ADDR, 32'h0);

        // R1 field masks
        wr(OFS_ADDR, 32'hFFFF_FFFF);
        rd_chk("R1 addr mask", OFS_ADDR, 32'h0000_1F1F);
        wr(OFS_WDATA, 32'hFFFF_1234);
        rd_chk("R1 wdata mask", OFS_WDATA, 32'h0000_1234);

        // R2 no request bits: nothing starts
        wr(OFS_CTRL, 32'hFFFF_FFF3);
        repeat (50) @(negedge clk);
        rd_chk("R2 no start", OFS_STAT, 32'h0);

        // write PHY reg 3
        wr(OFS_ADDR, {19'b0, PHY_ADDR, 3'b0, 5'd3});
        wr(OFS_WDATA, 32'h0000_BEEF);
        wr(OFS_CTRL, 32'h4);
        repeat (5) @(negedge clk);
        rd_chk("R8 ctrl shows write", OFS_CTRL, 32'h4);
        rd_chk("R3 busy", OFS_STAT, 32'h1);
        wait_idle();
        rd_chk("R8 self clear", OFS_CTRL, 32'h0);
        rd_chk("R7 write leaves rdata", OFS_RDATA, 32'h0);
        chk("R5 phy got write", {16'b0, phy_mem[3]}, 32'h0000_BEEF);

        // read back reg 3
        wr(OFS_CTRL, 32'h8);
        repeat (5) @(negedge clk);
        rd_chk("R8 ctrl shows read", OFS_CTRL, 32'h8);
        wait_idle();
        rd_chk("R6 read reg3", OFS_RDATA, 32'h0000_BEEF);

        // read initial pattern reg 7, both bits -> read (R2)
        wr(OFS_ADDR, {19'b0, PHY_ADDR, 3'b0, 5'd7});
        wr(OFS_CTRL, 32'hC);
        repeat (5) @(negedge clk);
        rd_chk("R2 both bits read", OFS_CTRL, 32'h8);
        wait_idle();
        rd_chk("R6 read reg7", OFS_RDATA, {16'b0, init_word(7)});
        rd_chk("R7 upper zero", OFS_RDATA, {16'b0, m_rdata});

        // R9 request while busy
        wr(OFS_ADDR, {19'b0, PHY_ADDR, 3'b0, 5'd10});
        wr(OFS_WDATA, 32'h0000_5A5A);
        wr(OFS_CTRL, 32'h4);
        repeat (100) @(negedge clk);
        wr(OFS_CTRL, 32'h8);
        rd_chk("R9 ctrl unchanged", OFS_CTRL, 32'h4);
        wait_idle();
        rd_chk("R9 rdata unchanged", OFS_RDATA, {16'b0, init_word(7)});
        wr(OFS_CTRL, 32'h8);
        wait_idle();
        rd_chk("R9 write completed", OFS_RDATA, 32'h0000_5A5A);

        // edge data pattern on reg 31
        wr(OFS_ADDR, {19'b0, PHY_ADDR, 3'b0, 5'd31});
        wr(OFS_WDATA, 32'h0000_8001);
        wr(OFS_CTRL, 32'h4);
        wait_idle();
        wr(OFS_CTRL, 32'h8);
        wait_idle();
        rd_chk("R6 read reg31", OFS_RDATA, 32'h0000_8001);

        // PHY number that nobody answers: line stays pulled up
        wr(OFS_ADDR, {19'b0, 5'd6, 3'b0, 5'd1});
        wr(OFS_CTRL, 32'h8);
        wait_idle();
        rd_chk("R6 absent phy", OFS_RDATA, 32'h0000_FFFF);
        rd_chk("R4 idle status", OFS_STAT, 32'h0);

        summary();
    end
endmodule